// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital side of a 10-bit successive-approximation analog-to-digital converter. It drives a trial code into an internal DAC and reads back one comparator bit from the analog front end. It resolves the result one bit at a time, starting at the most significant bit. It also drives the channel-select code to the input multiplexer and the reference-select code to the reference switch, and it raises an interrupt when a result is ready.

Software talks to the block through a small byte-wide register bus with four addresses:

| Address | Register | Access |
|---|---|---|
| 0 | control | read/write |
| 1 | selection | read/write |
| 2 | result low byte | read |
| 3 | result high byte | read |

A conversion is started by one control write that sets both the enable bit and the start bit. The block then latches the selections, holds a sample for one and a half converter clocks, and runs ten bit trials. The converter clock comes from a prescaler on the system clock. Code 0 means ground and code 1023 means the reference minus one LSB.

Selection codes pass straight through to the analog side:

- Channel codes 0 to 7 pick the external pins, 14 picks the bandgap and 15 picks ground.
- Reference code 0 picks the external reference pin, 1 the analog supply and 3 the internal 2.56 V reference.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset every register reads 0, `pwr_dn` is 1, and `irq`, `dac_code`, `chan_sel`, `ref_sel` and `sample_hold` are 0.
- R2: When the enable bit (control bit 7) is 0, the block is idle and drives `pwr_dn` high with `dac_code` 0 and `sample_hold` low. Clearing enable during a conversion aborts it without setting the flag, and the start bit then reads 0.
- R3: A start (control bit 6) is accepted only when the same write also sets enable and no conversion is running. Any other start write is ignored, and it neither restarts nor lengthens a running conversion.
- R4: Each trial drives the kept bits plus the bit under test on `dac_code`. The bit is kept when `cmp_in` is 1, meaning the input is at or above the trial. The trials go from bit 9 down to bit 0, so the result equals the input code, including 0 and 1023.
- R5: Prescaler code p (control bits 2:0) gives a converter clock of 2^max(p,1) system clocks. The flag is set exactly 23·2^(max(p,1)−1) system clocks after the edge that accepts the start.
- R6: The start bit reads 1 from the accepting edge until the completing edge, and 0 otherwise.
- R7: With the adjust bit (selection bit 7) at 0, address 3 reads {000000, r[9:8]} and address 2 reads r[7:0]. With it at 1, address 3 reads r[9:2] and address 2 reads {r[1:0], 000000}.
- R8: Completion sets the flag (control bit 4). `irq` equals the flag AND the interrupt-enable bit (control bit 3). Writing 1 to bit 4 clears the flag, and writing 0 leaves it unchanged.
- R9: When completion and a flag-clearing write fall on the same edge, the flag ends up set.
- R10: The channel field (selection bits 3:0) and the reference field (selection bits 5:4) reach `chan_sel` and `ref_sel` only while the block is enabled and idle, one clock later. They are latched on the accepting edge and held until the conversion ends.
- R11: Reading address 2 captures the high byte. Address 3 then returns that captured value, even if a newer conversion completes in between, until address 3 is read.
- R12: `sample_hold` is high for exactly 3·2^(max(p,1)−1) system clocks after the accepting edge, with `dac_code` 0. The first trial code is 0x200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (for read side effects) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| cmp_in | input | 1 | Comparator: 1 when input ≥ DAC trial |
| dac_code | output | 10 | Trial code to the DAC |
| sample_hold | output | 1 | Sample-and-hold tracking phase |
| chan_sel | output | 4 | Input multiplexer code |
| ref_sel | output | 2 | Reference selection code |
| pwr_dn | output | 1 | Analog power-down, high when disabled |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
Two events can land on the same clock edge: the completing trial setting the flag, and a software write that clears the flag. Because the conversion length follows directly from the prescaler code, the bench counts cycles from the accepting edge and places a clearing control write exactly on the completing edge. It judges the result by reading the control register afterwards and requiring the flag to be set. A second timing overlap places a start write in the middle of a running conversion, and the bench requires the interrupt to rise at the cycle computed from the first start alone.

// File: rtl/sar_adc_pkg.sv
// Package: shared encodings for the converter controller.
// Assumes a byte-wide bus of at least 8 bits.
package sar_adc_pkg;

    // Engine phases
    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_SAMPLE = 2'd1,
        ENG_TRIAL  = 2'd2
    } eng_state_t;

    // Register addresses
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_SEL  = 2'd1;
    localparam logic [1:0] ADDR_RLO  = 2'd2;
    localparam logic [1:0] ADDR_RHI  = 2'd3;

    // Control register bit positions
    localparam int CTRL_EN_BIT   = 7;
    localparam int CTRL_GO_BIT   = 6;
    localparam int CTRL_FLAG_BIT = 4;
    localparam int CTRL_IE_BIT   = 3;

endpackage

// File: rtl/sar_adc_prescale.sv
// Prescaler: produces a half-period tick of the converter clock.
// The converter clock is 2^max(ps,1) system clocks, so the tick comes every
// 2^(max(ps,1)-1) clocks. The counter restarts on a start so that timing is
// fixed from the accepting edge. Assumes ps stays constant during a conversion.
module sar_adc_prescale #(
    parameter int PS_W = 3,
    localparam int CNT_W = (1 << PS_W) - 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            restart,
    input  logic [PS_W-1:0] ps,
    output logic            half_tick
);

    logic [CNT_W-1:0] cnt;
    logic [PS_W-1:0]  expo;
    logic [CNT_W-1:0] mask;

    // Exponent of the half period; codes 0 and 1 both give one clock
    assign expo = (ps < PS_W'(2)) ? '0 : ps - PS_W'(1);
    // Low-bit mask; wraps to all ones for the largest exponent
    assign mask = (CNT_W'(1) << expo) - CNT_W'(1);
    assign half_tick = run && ((cnt & mask) == mask);

    // Free-running divider, cleared on start or while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || !run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/sar_adc_engine.sv
// Engine: bit-trial state machine. Samples for SAMPLE_HALVES half ticks, then
// tests each bit from the MSB down for TRIAL_HALVES half ticks each. Assumes
// cmp_in is settled by the last half tick of a trial.
module sar_adc_engine
    import sar_adc_pkg::*;
#(
    parameter int RES_W         = 10,
    parameter int SAMPLE_HALVES = 3,
    parameter int TRIAL_HALVES  = 2,
    localparam int IDX_W  = $clog2(RES_W),
    localparam int PH_MAX = (SAMPLE_HALVES > TRIAL_HALVES) ? SAMPLE_HALVES : TRIAL_HALVES,
    localparam int PH_W   = (PH_MAX > 1) ? $clog2(PH_MAX) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             start,
    input  logic             half_tick,
    input  logic             cmp_in,
    output logic             busy,
    output logic             sample,
    output logic [RES_W-1:0] dac_code,
    output logic             done,
    output logic [RES_W-1:0] result
);

    eng_state_t       state;
    logic [PH_W-1:0]  phase;
    logic [IDX_W-1:0] idx;
    logic [RES_W-1:0] sar;
    logic [RES_W-1:0] trial_bit;
    logic             trial_end;

    assign trial_bit = RES_W'(1) << idx;
    assign trial_end = (state == ENG_TRIAL) && half_tick
                       && (phase == PH_W'(TRIAL_HALVES - 1));
    assign done      = trial_end && (idx == '0);
    assign busy      = (state != ENG_IDLE);
    assign sample    = (state == ENG_SAMPLE);
    assign dac_code  = (state == ENG_TRIAL) ? (sar | trial_bit) : '0;

    // Phase sequencing and bit decisions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ENG_IDLE;
            phase  <= '0;
            idx    <= '0;
            sar    <= '0;
            result <= '0;
        end else if (start) begin
            state <= ENG_SAMPLE;
            phase <= '0;
        end else if (!en) begin
            state <= ENG_IDLE;
            phase <= '0;
        end else begin
            case (state)
                ENG_SAMPLE: begin
                    if (half_tick) begin
                        if (phase == PH_W'(SAMPLE_HALVES - 1)) begin
                            state <= ENG_TRIAL;
                            phase <= '0;
                            idx   <= IDX_W'(RES_W - 1);
                            sar   <= '0;
                        end else begin
                            phase <= phase + PH_W'(1);
                        end
                    end
                end
                ENG_TRIAL: begin
                    if (half_tick) begin
                        if (!trial_end) begin
                            phase <= phase + PH_W'(1);
                        end else begin
                            phase    <= '0;
                            sar[idx] <= cmp_in;
                            if (idx == '0) begin
                                state  <= ENG_IDLE;
                                result <= {sar[RES_W-1:1], cmp_in};
                            end else begin
                                idx <= idx - IDX_W'(1);
                            end
                        end
                    end
                end
                default: begin
                    phase <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sar_adc_regs.sv
// Register file: control, selection and result registers; the completion
// flag; and the high-byte capture for coherent two-byte reads. A start is
// accepted only when the write also sets enable and the engine is idle.
module sar_adc_regs
    import sar_adc_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int RES_W  = 10,
    parameter int PS_W   = 3,
    parameter int CH_W   = 4,
    parameter int REF_W  = 2,
    localparam int WORD_W = 2 * BYTE_W,
    localparam int PAD_W  = WORD_W - RES_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [RES_W-1:0]  result,
    output logic              en,
    output logic              start,
    output logic [PS_W-1:0]   ps,
    output logic [CH_W-1:0]   sel_chan,
    output logic [REF_W-1:0]  sel_ref,
    output logic              flag,
    output logic              irq
);

    logic              ie_q;
    logic              left_q;
    logic              held_q;
    logic [BYTE_W-1:0] hold_q;
    logic              wr_ctrl;
    logic              wr_sel;
    logic              rd_lo;
    logic              rd_hi;
    logic [WORD_W-1:0] word_r;
    logic [WORD_W-1:0] word_l;
    logic [WORD_W-1:0] word;
    logic [BYTE_W-1:0] hi_now;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
    assign wr_sel  = bus_wr && (bus_addr == ADDR_SEL);
    assign rd_lo   = bus_rd && (bus_addr == ADDR_RLO);
    assign rd_hi   = bus_rd && (bus_addr == ADDR_RHI);
    assign start   = wr_ctrl && bus_wdata[CTRL_EN_BIT]
                     && bus_wdata[CTRL_GO_BIT] && !busy;
    assign irq     = flag && ie_q;

    // Justification variants of the result word
    generate
        if (PAD_W > 0) begin : g_pad
            assign word_r = {{PAD_W{1'b0}}, result};
            assign word_l = {result, {PAD_W{1'b0}}};
        end else begin : g_nopad
            assign word_r = result;
            assign word_l = result;
        end
    endgenerate

    assign word   = left_q ? word_l : word_r;
    assign hi_now = word[WORD_W-1:BYTE_W];

    // Control fields written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            ie_q <= 1'b0;
            ps   <= '0;
        end else if (wr_ctrl) begin
            en   <= bus_wdata[CTRL_EN_BIT];
            ie_q <= bus_wdata[CTRL_IE_BIT];
            ps   <= bus_wdata[PS_W-1:0];
        end
    end

    // Selection fields written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_chan <= '0;
            sel_ref  <= '0;
            left_q   <= 1'b0;
        end else if (wr_sel) begin
            sel_chan <= bus_wdata[CH_W-1:0];
            sel_ref  <= bus_wdata[CH_W +: REF_W];
            left_q   <= bus_wdata[BYTE_W-1];
        end
    end

    // Completion flag: setting wins over a write-one clear on the same edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (done) begin
            flag <= 1'b1;
        end else if (wr_ctrl && bus_wdata[CTRL_FLAG_BIT]) begin
            flag <= 1'b0;
        end
    end

    // High-byte capture on a low-byte read, released by a high-byte read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            hold_q <= '0;
        end else if (rd_lo) begin
            held_q <= 1'b1;
            hold_q <= hi_now;
        end else if (rd_hi) begin
            held_q <= 1'b0;
        end
    end

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[CTRL_EN_BIT]   = en;
                bus_rdata[CTRL_GO_BIT]   = busy;
                bus_rdata[CTRL_FLAG_BIT] = flag;
                bus_rdata[CTRL_IE_BIT]   = ie_q;
                bus_rdata[PS_W-1:0]      = ps;
            end
            ADDR_SEL: begin
                bus_rdata[CH_W-1:0]      = sel_chan;
                bus_rdata[CH_W +: REF_W] = sel_ref;
                bus_rdata[BYTE_W-1]      = left_q;
            end
            ADDR_RLO: bus_rdata = word[BYTE_W-1:0];
            default:  bus_rdata = held_q ? hold_q : hi_now;
        endcase
    end

endmodule

// File: rtl/sar_adc_selhold.sv
// Selection gate: passes software selections to the analog side only while
// enabled and idle, latches them on the accepting edge, and holds them
// through a conversion and while disabled.
module sar_adc_selhold #(
    parameter int CH_W  = 4,
    parameter int REF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             busy,
    input  logic             start,
    input  logic [CH_W-1:0]  chan_in,
    input  logic [REF_W-1:0] ref_in,
    output logic [CH_W-1:0]  chan_out,
    output logic [REF_W-1:0] ref_out
);

    // Track or hold the selection codes driven to the analog side
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_out <= '0;
            ref_out  <= '0;
        end else if ((en || start) && !busy) begin
            chan_out <= chan_in;
            ref_out  <= ref_in;
        end
    end

endmodule

// File: rtl/sar_adc_ctrl.sv
// Top: digital controller of a successive-approximation converter. Joins
// the register file, prescaler, trial engine and selection gate. Assumes the
// analog comparator output is synchronous to clk.
module sar_adc_ctrl #(
    parameter int BYTE_W        = 8,
    parameter int RES_W         = 10,
    parameter int PS_W          = 3,
    parameter int CH_W          = 4,
    parameter int REF_W         = 2,
    parameter int SAMPLE_HALVES = 3,
    parameter int TRIAL_HALVES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              cmp_in,
    output logic [RES_W-1:0]  dac_code,
    output logic              sample_hold,
    output logic [CH_W-1:0]   chan_sel,
    output logic [REF_W-1:0]  ref_sel,
    output logic              pwr_dn,
    output logic              irq
);

    logic             en;
    logic             start;
    logic             busy;
    logic             flag;
    logic             conv_done;
    logic             half_tick;
    logic [PS_W-1:0]  ps;
    logic [CH_W-1:0]  sel_chan;
    logic [REF_W-1:0] sel_ref;
    logic [RES_W-1:0] result;

    assign pwr_dn = !en;

    sar_adc_regs #(
        .BYTE_W(BYTE_W), .RES_W(RES_W), .PS_W(PS_W), .CH_W(CH_W), .REF_W(REF_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .done      (conv_done),
        .result    (result),
        .en        (en),
        .start     (start),
        .ps        (ps),
        .sel_chan  (sel_chan),
        .sel_ref   (sel_ref),
        .flag      (flag),
        .irq       (irq)
    );

    sar_adc_prescale #(.PS_W(PS_W)) u_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (en),
        .restart   (start),
        .ps        (ps),
        .half_tick (half_tick)
    );

    sar_adc_engine #(
        .RES_W(RES_W), .SAMPLE_HALVES(SAMPLE_HALVES), .TRIAL_HALVES(TRIAL_HALVES)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .start     (start),
        .half_tick (half_tick),
        .cmp_in    (cmp_in),
        .busy      (busy),
        .sample    (sample_hold),
        .dac_code  (dac_code),
        .done      (conv_done),
        .result    (result)
    );

    sar_adc_selhold #(.CH_W(CH_W), .REF_W(REF_W)) u_selhold (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .busy     (busy),
        .start    (start),
        .chan_in  (sel_chan),
        .ref_in   (sel_ref),
        .chan_out (chan_sel),
        .ref_out  (ref_sel)
    );

endmodule

// File: rtl/sar_adc_ctrl_chk.sv
// Checker: temporal properties of the converter controller, bound to the top.
module sar_adc_ctrl_chk #(
    parameter int RES_W = 10,
    parameter int CH_W  = 4,
    parameter int REF_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_dn,
    input logic             sample_hold,
    input logic [RES_W-1:0] dac_code,
    input logic [CH_W-1:0]  chan_sel,
    input logic [REF_W-1:0] ref_sel,
    input logic             irq,
    input logic             busy,
    input logic             flag
);

    // R2
    idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_dn && $past(pwr_dn)) |-> (!busy && !sample_hold && dac_code == '0));

    // R3
    start_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !pwr_dn);

    // R12
    sample_dac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_hold |-> (dac_code == '0));

    // R8
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(busy));

    // R8
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag);

    // R10
    hold_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(chan_sel) && $stable(ref_sel)));

endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(
    .RES_W(RES_W), .CH_W(CH_W), .REF_W(REF_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_dn      (pwr_dn),
    .sample_hold (sample_hold),
    .dac_code    (dac_code),
    .chan_sel    (chan_sel),
    .ref_sel     (ref_sel),
    .irq         (irq),
    .busy        (busy),
    .flag        (flag)
);

// File: tb/test_sar_adc_ctrl.sv
module test_sar_adc_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic       sample_hold;
    logic [3:0] chan_sel;
    logic [1:0] ref_sel;
    logic       pwr_dn;
    logic       irq;

    logic [9:0] vin = 10'd0;
    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_c0 = 0;
    int exp_q[$];
    bit finished = 1'b0;
    logic irq_d = 1'b0;

    // Analog model: comparator high when the input is at or above the trial
    assign cmp_in = (vin >= dac_code);

    always #10 clk = ~clk;

    sar_adc_ctrl i_sar_adc_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp_in(cmp_in), .dac_code(dac_code), .sample_hold(sample_hold),
        .chan_sel(chan_sel), .ref_sel(ref_sel), .pwr_dn(pwr_dn), .irq(irq)
    );

    always @(posedge clk) cyc = cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // All bus tasks start and end at a falling edge
    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
    endtask

    function automatic int half_of(input int ps);
        return 1 << ((ps < 2) ? 0 : ps - 1);
    endfunction

    // Driver: start a conversion and push the expected completion cycle
    task automatic start_conv(input int ps, input logic [9:0] v, input bit push);
        vin = v;
        bus_write(2'd0, 8'hD8 | 8'(ps));
        last_c0 = cyc;
        if (push) exp_q.push_back(cyc + 23 * half_of(ps));
    endtask

    task automatic wait_irq();
        while (!irq) @(negedge clk);
    endtask

    task automatic check_result(input string req, input logic [9:0] r, input bit left);
        logic [7:0] lo;
        logic [7:0] hi;
        bus_read(2'd2, lo);
        bus_read(2'd3, hi);
        chk({req, " low byte"}, int'(lo), left ? int'({r[1:0], 6'b0}) : int'(r[7:0]));
        chk({req, " high byte"}, int'(hi), left ? int'(r[9:2]) : int'({6'b0, r[9:8]}));
    endtask

    // Monitor: compare completion timing against the scoreboard queue (R5)
    always @(negedge clk) begin
        if (irq && !irq_d && exp_q.size() > 0) begin
            chk("R5 completion cycle", cyc, exp_q.pop_front());
        end
        irq_d = irq;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [7:0] d;
        int n;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 pwr_dn", int'(pwr_dn), 1);
        chk("R1 irq", int'(irq), 0);
        chk("R1 dac_code", int'(dac_code), 0);
        chk("R1 chan_sel", int'(chan_sel), 0);
        chk("R1 sample_hold", int'(sample_hold), 0);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(2'd0, d); chk("R1 control", int'(d), 0);
        bus_read(2'd1, d); chk("R1 selection", int'(d), 0);
        bus_read(2'd3, d); chk("R1 result high", int'(d), 0);

        // R10 selections blocked while disabled, pass once enabled
        bus_write(2'd1, 8'h25);
        chk("R10 chan while disabled", int'(chan_sel), 0);
        chk("R10 ref while disabled", int'(ref_sel), 0);
        bus_write(2'd0, 8'h80);
        @(negedge clk);
        chk("R10 chan after enable", int'(chan_sel), 5);
        chk("R10 ref after enable", int'(ref_sel), 2);
        chk("R2 pwr_dn enabled", int'(pwr_dn), 0);

        // R3 start without enable is ignored
        bus_write(2'd0, 8'h40);
        bus_read(2'd0, d); chk("R3 start without enable", int'(d), 0);
        chk("R2 pwr_dn disabled", int'(pwr_dn), 1);
        bus_write(2'd1, 8'h13);
        chk("R10 chan held while disabled", int'(chan_sel), 5);

        // R4/R6/R7 basic conversion, right-justified, fastest clock
        start_conv(0, 10'h2AA, 1);
        chk("R10 chan latched at start", int'(chan_sel), 3);
        chk("R10 ref latched at start", int'(ref_sel), 1);
        bus_read(2'd0, d); chk("R6 start reads 1 while busy", int'(d), 8'hC8);
        wait_irq();
        bus_read(2'd0, d); chk("R8 flag set, R6 start cleared", int'(d), 8'h98);
        check_result("R4 R7 right 0x2AA", 10'h2AA, 1'b0);

        // R12 sampling window and first trial with divide-by-8
        start_conv(3, 10'h155, 1);
        n = 0;
        while (sample_hold) begin
            chk("R12 dac zero while sampling", int'(dac_code), 0);
            n++;
            @(negedge clk);
        end
        chk("R12 sample length", n, 12);
        chk("R12 first trial code", int'(dac_code), 10'h200);
        wait_irq();
        check_result("R4 0x155", 10'h155, 1'b0);

        // R4 extremes
        start_conv(1, 10'h000, 1);
        wait_irq();
        check_result("R4 zero", 10'h000, 1'b0);
        start_conv(2, 10'h3FF, 1);
        wait_irq();
        check_result("R4 full scale", 10'h3FF, 1'b0);

        // R7 left-justified
        bus_write(2'd1, 8'h93);
        start_conv(0, 10'h2D7, 1);
        wait_irq();
        check_result("R7 left 0x2D7", 10'h2D7, 1'b1);

        // R8 flag and interrupt enable
        chk("R8 irq raised", int'(irq), 1);
        bus_write(2'd0, 8'h88);
        bus_read(2'd0, d); chk("R8 write zero keeps flag", int'(d), 8'h98);
        bus_write(2'd0, 8'h80);
        chk("R8 irq masked", int'(irq), 0);
        bus_read(2'd0, d); chk("R8 flag kept while masked", int'(d), 8'h90);
        bus_write(2'd0, 8'h98);
        bus_read(2'd0, d); chk("R8 write one clears flag", int'(d), 8'h88);
        chk("R8 irq after clear", int'(irq), 0);

        // R3 start during busy ignored; R10 selection held during conversion
        bus_write(2'd1, 8'h13);
        start_conv(3, 10'h100, 1);
        repeat (20) @(negedge clk);
        bus_write(2'd0, 8'hCB);
        bus_write(2'd1, 8'h17);
        chk("R10 chan held while busy", int'(chan_sel), 3);
        wait_irq();
        check_result("R3 R4 0x100 after ignored start", 10'h100, 1'b0);
        chk("R10 chan after conversion", int'(chan_sel), 7);

        // R11 high byte captured by a low-byte read
        bus_read(2'd2, d); chk("R11 low byte", int'(d), 8'h00);
        start_conv(0, 10'h3FF, 1);
        wait_irq();
        bus_read(2'd3, d); chk("R11 frozen high byte", int'(d), 8'h01);
        bus_read(2'd3, d); chk("R11 released high byte", int'(d), 8'h03);

        // R9 completion and clear on the same edge
        start_conv(0, 10'h0F0, 1);
        while (cyc != last_c0 + 22) @(negedge clk);
        bus_write(2'd0, 8'h98);
        bus_read(2'd0, d); chk("R9 flag survives same-edge clear", int'(d), 8'h98);
        check_result("R4 0x0F0", 10'h0F0, 1'b0);

        // R2 abort by clearing enable
        start_conv(7, 10'h300, 0);
        repeat (100) @(negedge clk);
        bus_write(2'd0, 8'h00);
        chk("R2 pwr_dn after abort", int'(pwr_dn), 1);
        @(negedge clk);
        chk("R2 dac idle", int'(dac_code), 0);
        chk("R2 sample idle", int'(sample_hold), 0);
        bus_read(2'd0, d); chk("R2 aborted control", int'(d), 0);
        repeat (1500) @(negedge clk);
        bus_read(2'd0, d); chk("R2 no flag after abort", int'(d), 0);

        chk("R5 all completions seen", exp_q.size(), 0);
        summary();
    end

endmodule